// File: doc/BRIEF.md
# Temperature-Compensated Refresh Scheduler

This block belongs to a DRAM controller. It counts clock cycles and raises an auto-refresh request each time a refresh interval ends. The interval depends on the signed case temperature supplied to the block. It runs at the base length while the part is cool, and it drops to one half, one quarter or one eighth of that length as the temperature passes each upper band edge. The command sequencer acknowledges each refresh it issues. Any refresh that has not been acknowledged is held in a saturating pending count, and the request stays high until that count returns to zero.

The block also controls entry to self-refresh. A host request is granted only while the part is cool enough. While the grant is held, the interval timer is stopped and no auto-refresh is requested. If the part heats past the limit during self-refresh, the grant is withdrawn and one refresh is queued at once. Two registered flags tell the rest of the controller two things: that the extended-temperature refresh mode is in force, and that termination and driver impedance must be derated.

Top module: `trs_refresh_sched`

## Requirements
- R1: At a case temperature of +85 °C or below, with no acknowledges, the first refresh request rises exactly BASE_INTERVAL clock edges after reset is released, and a new interval ends every BASE_INTERVAL edges after that.
- R2: Above +85 °C the interval is BASE_INTERVAL/2. Above +105 °C it is BASE_INTERVAL/4. Above +115 °C it is BASE_INTERVAL/8. Each band edge is a strict "greater than", so +105 °C still gives the half interval.
- R3: If a rise in temperature makes the cycles already counted reach the new, shorter interval, the request rises on the very next clock edge.
- R4: Each interval that ends adds one to the pending count, which saturates at 8. ref_req is high exactly while the pending count is non-zero.
- R5: A cycle with ref_ack high removes one pending refresh. An ack while nothing is pending is ignored, so the count never goes below zero.
- R6: sr_grant follows sr_req one edge later while the temperature is +105 °C or below. It is never high in the cycle after the temperature was above +105 °C.
- R7: While sr_grant is high, the pending count is cleared and the interval timer is held at zero. After the grant ends, a full interval passes before the next request.
- R8: If the temperature is above +105 °C while sr_grant is high, sr_grant falls on the next edge and the pending count is set to exactly one refresh, so a single ack clears the request.
- R9: ext_temp is high one edge after any cycle in which the temperature is above +85 °C, and low otherwise.
- R10: derate is high one edge after any cycle in which the temperature is below 0 °C or above +85 °C, and low otherwise.
- R11: While rst_n is low at a clock edge, ref_req, sr_grant, ext_temp and derate are all low, whatever the inputs, and the interval and pending counts return to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| case_temp | input | TEMP_W | Case temperature, two's complement, whole degrees Celsius |
| ref_ack | input | 1 | Sequencer has issued one auto-refresh |
| sr_req | input | 1 | Host asks to enter self-refresh |
| ref_req | output | 1 | One or more auto-refreshes are owed |
| sr_grant | output | 1 | Self-refresh is permitted |
| ext_temp | output | 1 | Extended-temperature refresh mode is in force |
| derate | output | 1 | Impedance and termination must be derated |

## Verification
The bench measures the interval on each side of every band edge: +85/+86, +105/+106 and +115/+116. A design with the comparisons off by one would give the wrong interval at exactly one of those temperatures. It holds off acknowledges for ten intervals and then counts how many acks the request takes to clear. A counter that wraps instead of saturating, or that goes below zero on a stray ack, shows up as the wrong number of acks. It also raises the temperature sharply partway through an interval, where a design that applies the shorter interval only after the next reload would be late. Finally it exercises self-refresh entry, normal exit and forced exit on heat. A timer that keeps running during self-refresh would shorten the first interval after exit, and a design without the forced exit would leave the grant high or queue the wrong number of refreshes.

// File: rtl/trs_pkg.sv
// Package: shared types and band edges for the refresh scheduler.
// Assumes temperatures are whole degrees Celsius in two's complement.
package trs_pkg;
    // Band code doubles as the right-shift applied to the base interval.
    typedef enum logic [1:0] {
        BAND_1X = 2'd0,
        BAND_2X = 2'd1,
        BAND_4X = 2'd2,
        BAND_8X = 2'd3
    } band_e;

    localparam int EDGE_2X_C  = 85;   // strictly above: interval halved
    localparam int EDGE_4X_C  = 105;  // strictly above: quarter, self-refresh barred
    localparam int EDGE_8X_C  = 115;  // strictly above: eighth
    localparam int EDGE_COLD_C = 0;   // strictly below: derate
endpackage

// File: rtl/trs_temp_band.sv
// Module: trs_temp_band
// Sorts the live case temperature into a refresh band and a self-refresh
// bar (both combinational), and registers the extended-temperature and
// derating flags. Assumes TEMP_W is wide enough to hold the band edges.
module trs_temp_band
    import trs_pkg::*;
#(
    parameter int TEMP_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic signed [TEMP_W-1:0] temp,
    output band_e                    band,
    output logic                     hot,
    output logic                     ext_q,
    output logic                     derate_q
);
    // Band selection from the live temperature, hottest band first.
    always_comb begin
        if (temp > EDGE_8X_C)      band = BAND_8X;
        else if (temp > EDGE_4X_C) band = BAND_4X;
        else if (temp > EDGE_2X_C) band = BAND_2X;
        else                       band = BAND_1X;
    end

    assign hot = (temp > EDGE_4X_C);

    // Registered flags for the rest of the controller.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_q    <= 1'b0;
            derate_q <= 1'b0;
        end else begin
            ext_q    <= (temp > EDGE_2X_C);
            derate_q <= (temp > EDGE_2X_C) || (temp < EDGE_COLD_C);
        end
    end

    // The hot side of derating always comes with the extended mode.
    assert_ext_implies_derate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ext_q |-> derate_q);
endmodule

// File: rtl/trs_interval_timer.sv
// Module: trs_interval_timer
// Counts the cycles elapsed in the current refresh interval and pulses
// expire when they reach the band's interval. The limit follows the live
// band, so a shorter interval ends the current one at once. Assumes
// BASE_INTERVAL >= 8 so that every scaled interval is at least one cycle.
module trs_interval_timer
    import trs_pkg::*;
#(
    parameter int BASE_INTERVAL = 6240,
    parameter int CNT_W         = $clog2(BASE_INTERVAL + 1)
) (
    input  logic  clk,
    input  logic  rst_n,
    input  band_e band,
    input  logic  hold,
    output logic  expire
);
    logic [CNT_W-1:0] elapsed;
    logic [CNT_W-1:0] last_cnt;

    // Last count value of the interval for the present band.
    always_comb begin
        last_cnt = CNT_W'((BASE_INTERVAL >> band) - 1);
        expire   = !hold && (elapsed >= last_cnt);
    end

    // Elapsed-cycle counter: cleared on reset, hold or expiry.
    always_ff @(posedge clk) begin
        if (!rst_n || hold || expire) elapsed <= '0;
        else                          elapsed <= elapsed + CNT_W'(1);
    end

    assert_elapsed_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        elapsed < CNT_W'(BASE_INTERVAL));
    assert_hold_freezes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (elapsed == '0));
endmodule

// File: rtl/trs_pending_ctr.sv
// Module: trs_pending_ctr
// Saturating count of refreshes owed. Interval expiries add one and
// acknowledges remove one. Clear wins over load_one, which wins over
// counting. Assumes PEND_MAX >= 1.
module trs_pending_ctr #(
    parameter int PEND_MAX = 8,
    parameter int PEND_W   = $clog2(PEND_MAX + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic ack,
    input  logic clear,
    input  logic load_one,
    output logic req
);
    logic [PEND_W-1:0] pend;
    logic              inc;
    logic              dec;

    // An ack only counts when something is owed.
    always_comb begin
        dec = ack && (pend != '0);
        inc = expire;
    end

    // Pending count update with saturation at PEND_MAX.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) pend <= '0;
        else if (load_one)   pend <= PEND_W'(1);
        else if (inc && !dec) begin
            if (pend != PEND_W'(PEND_MAX)) pend <= pend + PEND_W'(1);
        end else if (dec && !inc) pend <= pend - PEND_W'(1);
    end

    assign req = (pend != '0);

    assert_pend_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pend <= PEND_W'(PEND_MAX));
    assert_ack_dec_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !expire && !clear && !load_one && pend != '0) |=> (pend == $past(pend) - PEND_W'(1)));
endmodule

// File: rtl/trs_refresh_sched.sv
// Module: trs_refresh_sched (top)
// Temperature-scaled auto-refresh scheduling with self-refresh gating.
// Assumes ref_ack is only asserted for refreshes the sequencer issued,
// and case_temp is already synchronous to clk.
module trs_refresh_sched
    import trs_pkg::*;
#(
    parameter int CLK_MHZ       = 800,
    parameter int REFI_NS       = 7800,
    parameter int BASE_INTERVAL = CLK_MHZ * REFI_NS / 1000,
    parameter int TEMP_W        = 8,
    parameter int PEND_MAX      = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic signed [TEMP_W-1:0] case_temp,
    input  logic                     ref_ack,
    input  logic                     sr_req,
    output logic                     ref_req,
    output logic                     sr_grant,
    output logic                     ext_temp,
    output logic                     derate
);
    localparam int CNT_W  = $clog2(BASE_INTERVAL + 1);
    localparam int PEND_W = $clog2(PEND_MAX + 1);

    band_e band;
    logic  hot;
    logic  expire;
    logic  sr_stay;
    logic  sr_kick;

    trs_temp_band #(.TEMP_W(TEMP_W)) band_i (
        .clk(clk), .rst_n(rst_n), .temp(case_temp),
        .band(band), .hot(hot), .ext_q(ext_temp), .derate_q(derate)
    );

    trs_interval_timer #(.BASE_INTERVAL(BASE_INTERVAL), .CNT_W(CNT_W)) timer_i (
        .clk(clk), .rst_n(rst_n), .band(band), .hold(sr_grant), .expire(expire)
    );

    // Self-refresh held in a cool band, or forced out by heat.
    always_comb begin
        sr_stay = sr_grant && !hot;
        sr_kick = sr_grant && hot;
    end

    trs_pending_ctr #(.PEND_MAX(PEND_MAX), .PEND_W(PEND_W)) pend_i (
        .clk(clk), .rst_n(rst_n), .expire(expire), .ack(ref_ack),
        .clear(sr_stay), .load_one(sr_kick), .req(ref_req)
    );

    // Self-refresh grant, refused in the hottest bands.
    always_ff @(posedge clk) begin
        if (!rst_n) sr_grant <= 1'b0;
        else        sr_grant <= sr_req && !hot;
    end

    assert_no_hot_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hot |=> !sr_grant);
    assert_hot_exit_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_grant && hot) |=> (ref_req && !sr_grant));
endmodule

// File: tb/trs_refresh_sched_tb.sv
module trs_refresh_sched_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int BASE       = 64;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic signed [7:0] case_temp = 8'sd25;
    logic             ref_ack = 1'b0;
    logic             sr_req = 1'b0;
    logic             ref_req, sr_grant, ext_temp, derate;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    trs_refresh_sched #(.BASE_INTERVAL(BASE), .TEMP_W(8), .PEND_MAX(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .case_temp(case_temp), .ref_ack(ref_ack),
        .sr_req(sr_req), .ref_req(ref_req), .sr_grant(sr_grant),
        .ext_temp(ext_temp), .derate(derate)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Table: {temp, expected ext_temp, expected derate, expected grant with sr_req high}
    localparam logic [10:0] VEC [11] = '{
        {8'hD8, 3'b011}, {8'hFF, 3'b011}, {8'h00, 3'b001}, {8'd25, 3'b001},
        {8'd85, 3'b001}, {8'd86, 3'b111}, {8'd105, 3'b111}, {8'd106, 3'b110},
        {8'd115, 3'b110}, {8'd116, 3'b110}, {8'd125, 3'b110}
    };

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Advance n edges, then settle 1 time unit past the edge.
    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic do_reset(logic signed [7:0] t);
        rst_n = 1'b0; ref_ack = 1'b0; sr_req = 1'b0; case_temp = t;
        step(2);
        rst_n = 1'b1;
    endtask

    task automatic edges_to_req(output int n);
        n = 0;
        while (!ref_req && n < 2000) begin
            step(1);
            n++;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=0", cycles);
            report();
        end
    end

    initial begin
        int n;
        // R11: reset forces outputs low even with hot temp and sr_req high
        rst_n = 1'b0; case_temp = 8'sd120; sr_req = 1'b1;
        step(2);
        check("R11 ref_req", ref_req, 0);
        check("R11 sr_grant", sr_grant, 0);
        check("R11 ext_temp", ext_temp, 0);
        check("R11 derate", derate, 0);

        // Table walk: R9, R10, R6
        rst_n = 1'b1;
        for (int i = 0; i < 11; i++) begin
            case_temp = VEC[i][10:3];
            sr_req = 1'b1;
            step(1);
            check("R9 ext_temp", ext_temp, VEC[i][2]);
            check("R10 derate", derate, VEC[i][1]);
            check("R6 sr_grant", sr_grant, VEC[i][0]);
        end

        // R1: base interval, first and second
        do_reset(8'sd25);
        edges_to_req(n); check("R1 first interval", n, BASE);
        do_reset(8'shD8);
        edges_to_req(n); check("R1 interval at -40", n, BASE);
        do_reset(8'sd85);
        edges_to_req(n); check("R1 interval at 85", n, BASE);

        // R2: scaled intervals at each side of the band edges
        do_reset(8'sd86);  edges_to_req(n); check("R2 interval at 86", n, BASE/2);
        do_reset(8'sd105); edges_to_req(n); check("R2 interval at 105", n, BASE/2);
        do_reset(8'sd106); edges_to_req(n); check("R2 interval at 106", n, BASE/4);
        do_reset(8'sd115); edges_to_req(n); check("R2 interval at 115", n, BASE/4);
        do_reset(8'sd116); edges_to_req(n); check("R2 interval at 116", n, BASE/8);

        // R4 + R5: two owed, two acks clear
        do_reset(8'sd25);
        step(2*BASE);
        check("R4 req after two intervals", ref_req, 1);
        ref_ack = 1'b1; step(1);
        check("R5 req after one of two acks", ref_req, 1);
        step(1); ref_ack = 1'b0;
        check("R5 req after two acks", ref_req, 0);

        // R4: saturation at 8 after ten intervals
        do_reset(8'sd25);
        step(10*BASE);
        check("R4 req saturated", ref_req, 1);
        ref_ack = 1'b1; step(7);
        check("R4 req after 7 acks", ref_req, 1);
        step(1); ref_ack = 1'b0;
        check("R4 req after 8 acks", ref_req, 0);

        // R5: ack with nothing owed is ignored
        do_reset(8'sd25);
        step(5);
        ref_ack = 1'b1; step(1); ref_ack = 1'b0;
        check("R5 stray ack", ref_req, 0);
        edges_to_req(n); check("R5 interval after stray ack", n, BASE - 6);
        ref_ack = 1'b1; step(1); ref_ack = 1'b0;
        check("R5 single ack clears", ref_req, 0);

        // R3: sharp rise mid-interval requests on the next edge
        do_reset(8'sd25);
        step(40);
        check("R3 no req before rise", ref_req, 0);
        case_temp = 8'sd120; step(1);
        check("R3 req on next edge", ref_req, 1);

        // R7: self-refresh freezes timer and suppresses requests
        do_reset(8'sd25);
        sr_req = 1'b1; step(1);
        check("R6 grant when cool", sr_grant, 1);
        step(150);
        check("R7 no req in self-refresh", ref_req, 0);
        sr_req = 1'b0; step(1);
        check("R7 grant released", sr_grant, 0);
        edges_to_req(n); check("R7 full interval after exit", n, BASE);

        // R8: heat during self-refresh forces exit and one refresh
        do_reset(8'sd25);
        sr_req = 1'b1; step(3);
        case_temp = 8'sd110; step(1);
        check("R8 grant dropped", sr_grant, 0);
        check("R8 one refresh queued", ref_req, 1);
        sr_req = 1'b0; ref_ack = 1'b1; step(1); ref_ack = 1'b0;
        check("R8 single ack clears", ref_req, 0);

        report();
    end
endmodule